// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side serial command decoder of a paged flash model. While chip select is low it collects a 32-bit command word from the serial data input, MSB first: an 8-bit opcode followed by three address or dummy bytes. The serial pins are oversampled by the core clock, and edges on the serial clock are detected inside the block.

Two commands hand work to a back-end engine. One copies an array page into the buffer and one compares an array page with the buffer. For both, the block takes a 10-bit page number out of the address word. Where that field sits depends on the page-size mode. The block issues a single-cycle start pulse only when chip select rises after a complete command. A third command streams a 128-byte read-only security register out on the serial output, starting right after the last dummy bit. Raising chip select ends the stream and turns the output driver off.

Top module: `sflash_cmd_front`

## Requirements
- R1: After reset, so_oe_o and start_o are low.
- R2: The block samples si_i on rising edges of sck_i while cs_ni is low, MSB first. The first 8 bits form the opcode and the next 24 bits form the address word, with address bit 23 arriving first.
- R3: With page_mode_i = 0 (264-byte pages), page_o is taken from address bits 18 down to 9.
- R4: With page_mode_i = 1 (256-byte pages), page_o is taken from address bits 17 down to 8.
- R5: After a complete opcode 0x53 or 0x60, start_o pulses high for exactly one clock once cs_ni rises, and not before. With the pulse, op_cmp_o is 0 for 0x53 (page to buffer transfer) and 1 for 0x60 (page to buffer compare), and page_o carries the extracted page.
- R6: If cs_ni rises before all 32 command bits have arrived, no start pulse is issued.
- R7: Opcode 0x77 and any opcode other than 0x53 or 0x60 never produce a start pulse.
- R8: After the 32nd bit of opcode 0x77, so_oe_o goes high. On each falling sck_i edge so_o presents the next bit of the security register, MSB first. Byte k is (k*37 + 0xA5) mod 256 for k from 0 to 127.
- R9: Once the 128 security bytes have been shifted out, further bytes read as 0xFF.
- R10: A rise of cs_ni drops so_oe_o and clears the read position, so the next read starts again at byte 0.
- R11: Extra sck_i pulses after the 32nd bit of a launch command are ignored, and the page and operation taken at the cs_ni rise are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| page_mode_i | input | 1 | 0: 264-byte pages, 1: 256-byte pages |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o; low means high impedance |
| start_o | output | 1 | One-cycle launch pulse to the back-end engine |
| op_cmp_o | output | 1 | Launched operation: 0 transfer, 1 compare |
| page_o | output | 10 | Page number for the launched operation |

## Verification
The bench sends address words in both page-size modes, with the don't-care bits set to ones and also to zeros, so that a field taken one bit off, or taken from the wrong mode, shows up as a wrong page number. It holds chip select low after a complete launch command to catch a design that starts on the last address bit. It also cuts a command short, which a design without a complete-command check would launch anyway. The security read runs past byte 127 to catch a byte counter that wraps instead of producing fill bytes. The bench aborts a read partway through and then reads again, which exposes a byte position that survives chip select.

// File: rtl/sfcf_pkg.sv
package sfcf_pkg;
  localparam logic [7:0] OPC_SEC_RD = 8'h77;
  localparam logic [7:0] OPC_XFER   = 8'h53;
  localparam logic [7:0] OPC_CMP    = 8'h60;
  localparam int unsigned CMD_BITS  = 32;
  localparam int unsigned OPC_BITS  = 8;
  localparam int unsigned ADR_BITS  = CMD_BITS - OPC_BITS;
endpackage

// File: rtl/sfcf_sync.sv
module sfcf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic cs_q_o,
  output logic si_q_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o
);
  logic [STAGES-1:0] cs_p, sck_p, si_p;
  logic cs_d, sck_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cs_p[g]  <= 1'b1;
        sck_p[g] <= 1'b0;
        si_p[g]  <= 1'b0;
      end else if (g == 0) begin
        cs_p[g]  <= cs_ni;
        sck_p[g] <= sck_i;
        si_p[g]  <= si_i;
      end else begin
        cs_p[g]  <= cs_p[(g == 0) ? 0 : g-1];
        sck_p[g] <= sck_p[(g == 0) ? 0 : g-1];
        si_p[g]  <= si_p[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_p[STAGES-1];
      sck_d <= sck_p[STAGES-1];
    end
  end

  assign cs_q_o     = cs_p[STAGES-1];
  assign si_q_o     = si_p[STAGES-1];
  assign sck_rise_o = sck_p[STAGES-1] & ~sck_d & ~cs_q_o;
  assign sck_fall_o = ~sck_p[STAGES-1] & sck_d & ~cs_q_o;
  assign cs_rise_o  = cs_q_o & ~cs_d;
endmodule

// File: rtl/sfcf_rx.sv
module sfcf_rx
  import sfcf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_q_i,
  input  logic                si_q_i,
  input  logic                sck_rise_i,
  output logic                full_o,
  output logic [OPC_BITS-1:0] opcode_o,
  output logic [ADR_BITS-1:0] addr_o
);
  localparam int unsigned CNT_W = $clog2(CMD_BITS + 1);

  logic [CNT_W-1:0]    cnt_q;
  logic [CMD_BITS-1:0] shreg_q;

  assign full_o = (cnt_q == CNT_W'(CMD_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (cs_q_i) begin
      cnt_q <= '0;
    end else if (sck_rise_i && !full_o) begin
      shreg_q <= {shreg_q[CMD_BITS-2:0], si_q_i};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign opcode_o = shreg_q[CMD_BITS-1 -: OPC_BITS];
  assign addr_o   = shreg_q[ADR_BITS-1:0];
endmodule

// File: rtl/sfcf_decode.sv
module sfcf_decode
  import sfcf_pkg::*;
#(
  parameter int unsigned PAGE_W  = 10,
  parameter int unsigned STD_LSB = 9,
  parameter int unsigned BIN_LSB = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_rise_i,
  input  logic                full_i,
  input  logic [OPC_BITS-1:0] opcode_i,
  input  logic [ADR_BITS-1:0] addr_i,
  input  logic                page_mode_i,
  output logic                rd_active_o,
  output logic                start_o,
  output logic                op_cmp_o,
  output logic [PAGE_W-1:0]   page_o
);
  logic [PAGE_W-1:0] page_sel;
  logic              is_launch, launch;

  always_comb begin
    page_sel  = page_mode_i ? addr_i[BIN_LSB +: PAGE_W] : addr_i[STD_LSB +: PAGE_W];
    is_launch = (opcode_i == OPC_XFER) || (opcode_i == OPC_CMP);
    launch    = cs_rise_i && full_i && is_launch;
  end

  assign rd_active_o = full_i && (opcode_i == OPC_SEC_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o  <= 1'b0;
      op_cmp_o <= 1'b0;
      page_o   <= '0;
    end else begin
      start_o <= launch;
      if (launch) begin
        op_cmp_o <= (opcode_i == OPC_CMP);
        page_o   <= page_sel;
      end
    end
  end
endmodule

// File: rtl/sfcf_tx.sv
module sfcf_tx #(
  parameter int unsigned SEC_BYTES = 128,
  parameter int unsigned SEC_MUL   = 37,
  parameter int unsigned SEC_ADD   = 165,
  parameter logic [7:0]  FILL      = 8'hFF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_active_i,
  input  logic sck_fall_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int unsigned AW    = $clog2(SEC_BYTES);
  localparam int unsigned IDX_W = $clog2(SEC_BYTES + 1);

  logic [7:0]       sec_mem [SEC_BYTES];
  logic [IDX_W-1:0] byte_idx_q;
  logic [2:0]       bit_pos_q;
  logic             so_q;
  logic [7:0]       cur_byte;

  for (genvar g = 0; g < SEC_BYTES; g++) begin : g_sec
    assign sec_mem[g] = 8'((g * SEC_MUL + SEC_ADD) % 256);
  end

  assign cur_byte = (byte_idx_q < IDX_W'(SEC_BYTES)) ? sec_mem[byte_idx_q[AW-1:0]] : FILL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_idx_q <= '0;
      bit_pos_q  <= '0;
      so_q       <= 1'b0;
    end else if (!rd_active_i) begin
      byte_idx_q <= '0;
      bit_pos_q  <= '0;
      so_q       <= 1'b0;
    end else if (sck_fall_i) begin
      so_q      <= cur_byte[3'd7 - bit_pos_q];
      bit_pos_q <= bit_pos_q + 1'b1;
      // saturate at the end: later bytes read as fill
      if (bit_pos_q == 3'd7 && byte_idx_q != IDX_W'(SEC_BYTES))
        byte_idx_q <= byte_idx_q + 1'b1;
    end
  end

  assign so_oe_o = rd_active_i;
  assign so_o    = rd_active_i & so_q;
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import sfcf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PAGE_W      = 10,
  parameter int unsigned SEC_BYTES   = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              page_mode_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              start_o,
  output logic              op_cmp_o,
  output logic [PAGE_W-1:0] page_o
);
  logic cs_q, si_q, sck_rise, sck_fall, cs_rise;
  logic cmd_full, rd_active;
  logic [OPC_BITS-1:0] opcode;
  logic [ADR_BITS-1:0] addr;

  sfcf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .cs_q_o(cs_q), .si_q_o(si_q), .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall), .cs_rise_o(cs_rise)
  );

  sfcf_rx u_rx (
    .clk_i, .rst_ni, .cs_q_i(cs_q), .si_q_i(si_q), .sck_rise_i(sck_rise),
    .full_o(cmd_full), .opcode_o(opcode), .addr_o(addr)
  );

  sfcf_decode #(.PAGE_W(PAGE_W)) u_dec (
    .clk_i, .rst_ni, .cs_rise_i(cs_rise), .full_i(cmd_full),
    .opcode_i(opcode), .addr_i(addr), .page_mode_i,
    .rd_active_o(rd_active), .start_o, .op_cmp_o, .page_o
  );

  sfcf_tx #(.SEC_BYTES(SEC_BYTES)) u_tx (
    .clk_i, .rst_ni, .rd_active_i(rd_active), .sck_fall_i(sck_fall),
    .so_o, .so_oe_o
  );
endmodule

// File: rtl/sfcf_checker.sv
module sfcf_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_q,
  input logic sck_fall,
  input logic cmd_full,
  input logic start_o,
  input logic so_oe_o,
  input logic so_o
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R5
  AST_START_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(cmd_full)); // R6
  AST_NO_START_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> !start_o); // R7
  AST_SO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_oe_o && $past(so_oe_o) && !$past(sck_fall)) |-> $stable(so_o)); // R8
  AST_OE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |=> !so_oe_o); // R10
endmodule

bind sflash_cmd_front sfcf_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_q(cs_q), .sck_fall(sck_fall),
  .cmd_full(cmd_full), .start_o(start_o), .so_oe_o(so_oe_o), .so_o(so_o)
);

// File: tb/sflash_cmd_front_tb_top.sv
module sflash_cmd_front_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, mode = 1'b0;
  logic so, so_oe, start, op_cmp;
  logic [9:0] page;
  int checks = 0, errors = 0, starts = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sflash_cmd_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .page_mode_i(mode), .so_o(so), .so_oe_o(so_oe), .start_o(start),
    .op_cmp_o(op_cmp), .page_o(page)
  );

  always @(posedge clk) if (start) starts++;

  // opcode, address, mode, exp_start, exp_cmp, exp_page
  localparam logic [44:0] VEC [7] = '{
    {8'h53, 24'hFD57FF, 1'b0, 1'b1, 1'b0, 10'h2AB},
    {8'h60, 24'h02AA00, 1'b0, 1'b1, 1'b1, 10'h155},
    {8'h53, 24'hFFC1FF, 1'b1, 1'b1, 1'b0, 10'h3C1},
    {8'h60, 24'h000100, 1'b1, 1'b1, 1'b1, 10'h001},
    {8'hA5, 24'h123456, 1'b0, 1'b0, 1'b0, 10'h000},
    {8'h60, 24'h03FF00, 1'b1, 1'b1, 1'b1, 10'h3FF},
    {8'h53, 24'h03FF00, 1'b0, 1'b1, 1'b0, 10'h1FF}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic begin_cmd();
    @(negedge clk);
    sck = 1'b0;
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic send_bits(logic [31:0] w, int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0;
      si = w[31-i];
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic end_cmd();
    sck = 1'b0;
    tick(HALF);
    cs_n = 1'b1;
    tick(12);
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0;
      tick(HALF);
      b[7-i] = so;
      sck = 1'b1;
      tick(HALF);
    end
  endtask

  function automatic logic [7:0] sec_byte(int k);
    return (k < 128) ? 8'((k * 37 + 165) % 256) : 8'hFF;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] b;
    int s0;
    tick(3);
    check(so_oe == 1'b0 && start == 1'b0, "R1 reset outputs", {so_oe, start}, 0);
    rst_n = 1'b1;
    tick(3);
    check(so_oe == 1'b0 && start == 1'b0, "R1 after reset release", {so_oe, start}, 0);

    // table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < 7; v++) begin
      logic [44:0] e;
      e = VEC[v];
      mode = e[12];
      s0 = starts;
      begin_cmd();
      send_bits({e[44:37], e[36:13]}, 32);
      end_cmd();
      check((starts - s0) == int'(e[11]), "R5 R7 start count", starts - s0, int'(e[11]));
      if (e[11]) begin
        check(op_cmp == e[10], "R5 operation", op_cmp, e[10]);
        check(page == e[9:0], e[12] ? "R4 binary page" : "R3 standard page", page, e[9:0]);
      end
    end

    // R5: no launch while cs stays low
    mode = 1'b0;
    s0 = starts;
    begin_cmd();
    send_bits({8'h60, 24'h000600}, 32);
    sck = 1'b0;
    tick(20);
    check(starts == s0, "R5 no start before cs rise", starts - s0, 0);
    cs_n = 1'b1;
    tick(12);
    check(starts - s0 == 1 && page == 10'h003, "R5 start on cs rise", page, 10'h003);

    // R6: short command
    s0 = starts;
    begin_cmd();
    send_bits({8'h53, 24'h055600}, 24);
    end_cmd();
    check(starts == s0, "R6 short command discarded", starts - s0, 0);
    check(page == 10'h003, "R6 page untouched", page, 10'h003);

    // R11: extra clocks after a full launch command
    s0 = starts;
    begin_cmd();
    send_bits({8'h53, 24'h000E00}, 32);
    send_bits(32'hFFFF_FFFF, 8);
    end_cmd();
    check(starts - s0 == 1 && page == 10'h007 && op_cmp == 1'b0,
          "R11 extra clocks ignored", page, 10'h007);

    // R8 R9 full security read, R7 no start
    s0 = starts;
    begin_cmd();
    send_bits({8'h77, 24'hFFFFFF}, 32);
    check(so_oe == 1'b1, "R8 output enabled", so_oe, 1);
    for (int k = 0; k < 130; k++) begin
      read_byte(b);
      check(b == sec_byte(k), k < 128 ? "R8 security byte" : "R9 fill byte", b, sec_byte(k));
    end
    end_cmd();
    check(starts == s0, "R7 read gives no start", starts - s0, 0);

    // R10 abort and restart
    begin_cmd();
    send_bits({8'h77, 24'h000000}, 32);
    read_byte(b);
    read_byte(b);
    read_byte(b);
    check(b == sec_byte(2), "R8 third byte", b, sec_byte(2));
    end_cmd();
    check(so_oe == 1'b0, "R10 output released", so_oe, 0);
    begin_cmd();
    send_bits({8'h77, 24'h000000}, 32);
    read_byte(b);
    check(b == sec_byte(0), "R10 read restarts at byte 0", b, sec_byte(0));
    end_cmd();
    check(so_oe == 1'b0, "R10 output released again", so_oe, 0);

    summary();
  end
endmodule